// File: doc/BRIEF.md
# Streaming FFT Input Frame Sequencer

This block sits in front of a streaming FFT engine that takes several complex samples per clock. Each clock carries one group of `LANES` samples, and a single valid bit qualifies the whole group. The FFT has no backpressure. Once a transform starts, the group valid must stay high for exactly `FFT_LEN/LANES` clocks. The sequencer counts those beats. It marks the first beat and the last beat of each frame, and it passes the lane data through one register stage so that data and frame markers stay aligned.

The per-stage scale-control word is `log2(FFT_LEN)` bits wide. The sequencer captures it on the first beat of every frame and presents the captured copy to the arithmetic for the whole frame. Frames may follow one another with no idle clock between them. The sequencer detects two kinds of protocol violation: a valid that drops before the frame is complete, and a scale word that changes inside a frame. Either one sets a sticky error flag, and only reset clears that flag.

The control path is a two-state machine. `SEQ_IDLE` waits for a beat. A valid beat in idle is a frame start and takes the machine to `SEQ_RUN`. `SEQ_RUN` counts beats. It goes back to `SEQ_IDLE` in two cases: on the last beat of the frame (normal completion), or on a clock with valid low (a gap abort, which raises the error). All other valid beats keep the machine in `SEQ_RUN`.

Top module: `fft_frame_seq`

## Requirements
- R1: A synchronous active-high reset sets all outputs to zero on the next clock edge: `out_vld`, lane data, `frm_pos`, `sof`, `eof`, `scale_hold` and `proto_err`.
- R2: `out_vld`, `out_re` and `out_im` repeat `in_vld`, `in_re` and `in_im` exactly one clock later. Lane k occupies bits `[k*SAMP_W +: SAMP_W]`.
- R3: The first valid beat after idle, or after a completed frame, is a frame start. Its output cycle shows `sof`=1 and `frm_pos`=0.
- R4: Consecutive valid beats of a frame show `frm_pos` = 0, 1, … `FFT_LEN/LANES-1`. `eof` is 1 only on the beat at position `FFT_LEN/LANES-1`, and `sof` and `eof` are never high together.
- R5: When valid stays high across a frame boundary, the beat after `eof` is a new frame start (`sof`=1, `frm_pos`=0) and raises no error.
- R6: A valid-low clock inside a frame sets `proto_err`, which is visible one clock later. The next valid beat starts a new frame at position 0.
- R7: `scale_hold` takes the value of `scale_in` on each frame-start beat. If `scale_in` changes on a later beat of the same frame, `proto_err` is set and `scale_hold` keeps its value.
- R8: A change of `scale_in` while idle, or on the first beat of a frame (including a back-to-back frame start), is accepted without error, and the new value is captured.
- R9: Once set, `proto_err` stays at 1 through later correct frames until reset.
- R10: Clocks with valid low outside a frame give `sof`=0, `eof`=0, `frm_pos`=0 and do not change `proto_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Valid for the current sample group |
| in_re | input | LANES*SAMP_W | Real parts, one field per lane |
| in_im | input | LANES*SAMP_W | Imaginary parts, one field per lane |
| scale_in | input | log2(FFT_LEN) | Per-stage scale-control word |
| out_vld | output | 1 | Registered group valid |
| out_re | output | LANES*SAMP_W | Registered real parts |
| out_im | output | LANES*SAMP_W | Registered imaginary parts |
| frm_pos | output | log2(FFT_LEN/LANES) | Beat position of the registered group within its frame |
| sof | output | 1 | First beat of a frame |
| eof | output | 1 | Last beat of a frame |
| scale_hold | output | log2(FFT_LEN) | Scale word captured at the current frame start |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
Every result of this block appears exactly one clock after the beat that causes it. That holds for the data and valid pipeline, the position count, both frame markers, the captured scale word and the error flag. The bench drives each beat on the falling edge and pushes that beat's expected outputs into a queue at the same moment. The monitor pops one entry 2 ns after the next rising edge, so every comparison falls in the single cycle in which that beat's result is due. Reset values are checked on the falling edge after the reset edge, while the queue is empty.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/fft_seq_lane_reg.sv
module fft_seq_lane_reg #(
    parameter int SAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SAMP_W-1:0] d_re,
    input  logic [SAMP_W-1:0] d_im,
    output logic [SAMP_W-1:0] q_re,
    output logic [SAMP_W-1:0] q_im
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_re <= '0;
            q_im <= '0;
        end else begin
            q_re <= d_re;
            q_im <= d_im;
        end
    end

    // R2
    lane_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (q_re == $past(d_re) && q_im == $past(d_im)));

endmodule

// File: rtl/fft_seq_scale_guard.sv
module fft_seq_scale_guard #(
    parameter int SCL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             frame_run,
    input  logic             beat_vld,
    input  logic [SCL_W-1:0] scale_in,
    output logic [SCL_W-1:0] held_q,
    output logic             scale_bad
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (frame_start) begin
            held_q <= scale_in;
        end
    end

    always_comb begin
        scale_bad = frame_run && beat_vld && (scale_in != held_q);
    end

    // R7
    held_capture_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (held_q == $past(scale_in)));

    // R7
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !$past(rst)) |=> $stable(held_q));

endmodule

// File: rtl/fft_seq_ctrl.sv
module fft_seq_ctrl
    import fft_seq_pkg::*;
#(
    parameter int FRAME_BEATS = 256,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_vld,
    input  logic             scale_bad,
    output logic             frame_start,
    output logic             frame_run,
    output logic [CNT_W-1:0] pos_q,
    output logic             sof_q,
    output logic             eof_q,
    output logic             err_q
);

    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(FRAME_BEATS - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             at_last;
    logic             gap_hit;

    always_comb begin
        frame_start = beat_vld && (state_q == SEQ_IDLE);
        frame_run   = (state_q == SEQ_RUN);
        at_last     = (cnt_q == LAST_BEAT);
        gap_hit     = frame_run && !beat_vld;
        state_d     = state_q;
        cnt_d       = cnt_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (beat_vld) begin
                    state_d = SEQ_RUN;
                    cnt_d   = CNT_W'(1);
                end else begin
                    cnt_d   = '0;
                end
            end
            SEQ_RUN: begin
                if (!beat_vld || at_last) begin
                    state_d = SEQ_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = SEQ_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
            sof_q <= 1'b0;
            eof_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    pos_q <= '0;
                    sof_q <= beat_vld;
                    eof_q <= 1'b0;
                end
                SEQ_RUN: begin
                    pos_q <= beat_vld ? cnt_q : '0;
                    sof_q <= 1'b0;
                    eof_q <= beat_vld && at_last;
                end
                default: begin
                    pos_q <= '0;
                    sof_q <= 1'b0;
                    eof_q <= 1'b0;
                end
            endcase
            err_q <= err_q || gap_hit || scale_bad;
        end
    end

    // R3
    sof_pos_chk: assert property (@(posedge clk) disable iff (rst)
        sof_q |-> (pos_q == '0));

    // R4
    eof_pos_chk: assert property (@(posedge clk) disable iff (rst)
        eof_q |-> (pos_q == LAST_BEAT));

    // R4
    marker_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sof_q, eof_q}));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_BEAT);

    // R10
    idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE) |-> (cnt_q == '0));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R6
    gap_err_chk: assert property (@(posedge clk) disable iff (rst)
        gap_hit |=> err_q);

endmodule

// File: rtl/fft_frame_seq.sv
module fft_frame_seq #(
    parameter int FFT_LEN = 1024,
    parameter int LANES   = 4,
    parameter int SAMP_W  = 16,
    localparam int LOG2N       = $clog2(FFT_LEN),
    localparam int FRAME_BEATS = FFT_LEN / LANES,
    localparam int CNT_W       = $clog2(FRAME_BEATS),
    localparam int BUS_W       = LANES * SAMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [BUS_W-1:0] in_re,
    input  logic [BUS_W-1:0] in_im,
    input  logic [LOG2N-1:0] scale_in,
    output logic             out_vld,
    output logic [BUS_W-1:0] out_re,
    output logic [BUS_W-1:0] out_im,
    output logic [CNT_W-1:0] frm_pos,
    output logic             sof,
    output logic             eof,
    output logic [LOG2N-1:0] scale_hold,
    output logic             proto_err
);

    logic frame_start;
    logic frame_run;
    logic scale_bad;

    fft_seq_ctrl #(
        .FRAME_BEATS (FRAME_BEATS),
        .CNT_W       (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .beat_vld    (in_vld),
        .scale_bad   (scale_bad),
        .frame_start (frame_start),
        .frame_run   (frame_run),
        .pos_q       (frm_pos),
        .sof_q       (sof),
        .eof_q       (eof),
        .err_q       (proto_err)
    );

    fft_seq_scale_guard #(
        .SCL_W (LOG2N)
    ) u_guard (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .frame_run   (frame_run),
        .beat_vld    (in_vld),
        .scale_in    (scale_in),
        .held_q      (scale_hold),
        .scale_bad   (scale_bad)
    );

    genvar ln;
    generate
        for (ln = 0; ln < LANES; ln++) begin : g_lane
            fft_seq_lane_reg #(
                .SAMP_W (SAMP_W)
            ) u_lane (
                .clk  (clk),
                .rst  (rst),
                .d_re (in_re[ln*SAMP_W +: SAMP_W]),
                .d_im (in_im[ln*SAMP_W +: SAMP_W]),
                .q_re (out_re[ln*SAMP_W +: SAMP_W]),
                .q_im (out_im[ln*SAMP_W +: SAMP_W])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
        end
    end

    // R2
    vld_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_vld == $past(in_vld)));

    // R3
    sof_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
        sof |-> out_vld);

    // R7
    sof_scale_chk: assert property (@(posedge clk) disable iff (rst)
        sof |-> (scale_hold == $past(scale_in)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> (!sof && !eof && frm_pos == '0));

endmodule

// File: tb/fft_frame_seq_tb.sv
module fft_frame_seq_tb;

    localparam int N     = 32;
    localparam int R     = 4;
    localparam int W     = 8;
    localparam int LOGN  = $clog2(N);
    localparam int BEATS = N / R;
    localparam int CW    = $clog2(BEATS);
    localparam int BW    = R * W;

    typedef struct {
        logic          vld;
        logic [BW-1:0] re;
        logic [BW-1:0] im;
        int            pos;
        logic          sof;
        logic          eof;
        logic          err;
        logic [LOGN-1:0] scl;
        string         req;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_vld = 1'b0;
    logic [BW-1:0]   in_re = '0;
    logic [BW-1:0]   in_im = '0;
    logic [LOGN-1:0] scale_in = '0;
    logic            out_vld;
    logic [BW-1:0]   out_re;
    logic [BW-1:0]   out_im;
    logic [CW-1:0]   frm_pos;
    logic            sof;
    logic            eof;
    logic [LOGN-1:0] scale_hold;
    logic            proto_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    exp_t q[$];

    // reference model state
    bit              m_run = 0;
    int              m_cnt = 0;
    bit              m_err = 0;
    logic [LOGN-1:0] m_held = '0;
    int              dseq = 1;

    always #4 clk = ~clk;

    fft_frame_seq #(.FFT_LEN(N), .LANES(R), .SAMP_W(W)) u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
        .scale_in(scale_in), .out_vld(out_vld), .out_re(out_re), .out_im(out_im),
        .frm_pos(frm_pos), .sof(sof), .eof(eof), .scale_hold(scale_hold),
        .proto_err(proto_err)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic beat(input bit v, input logic [LOGN-1:0] sc, input string req);
        exp_t e;
        @(negedge clk);
        in_vld   = v;
        scale_in = sc;
        in_re    = BW'(dseq * 32'h01030507);
        in_im    = BW'(~(dseq * 32'h0b0d1113));
        dseq++;
        e.vld = v; e.re = in_re; e.im = in_im;
        e.pos = 0; e.sof = 0; e.eof = 0; e.req = req;
        if (v && !m_run) begin
            e.sof = 1; m_held = sc; m_run = 1; m_cnt = 1;
        end else if (v && m_run) begin
            e.pos = m_cnt;
            if (sc != m_held) m_err = 1;
            if (m_cnt == BEATS - 1) begin
                e.eof = 1; m_run = 0; m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end else if (!v && m_run) begin
            m_err = 1; m_run = 0; m_cnt = 0;
        end
        e.err = m_err;
        e.scl = m_held;
        q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; in_vld = 0;
        @(negedge clk);
        rst = 0;
        m_run = 0; m_cnt = 0; m_err = 0; m_held = '0;
        // R1: reset values observed after the reset edge
        chk("R1", "out_vld", out_vld, 0);
        chk("R1", "data", {out_re, out_im}, 0);
        chk("R1", "frm_pos", frm_pos, 0);
        chk("R1", "sof/eof", {sof, eof}, 0);
        chk("R1", "scale_hold", scale_hold, 0);
        chk("R1", "proto_err", proto_err, 0);
    endtask

    task automatic frame(input logic [LOGN-1:0] sc, input string req);
        for (int i = 0; i < BEATS; i++) beat(1, sc, req);
    endtask

    // monitor: compares one expected item per clock
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.req, "out_vld", out_vld, e.vld);
                chk(e.req, "out_re", out_re, e.re);
                chk(e.req, "out_im", out_im, e.im);
                chk(e.req, "frm_pos", frm_pos, e.pos);
                chk(e.req, "sof", sof, e.sof);
                chk(e.req, "eof", eof, e.eof);
                chk(e.req, "proto_err", proto_err, e.err);
                chk(e.req, "scale_hold", scale_hold, e.scl);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        do_reset();
        // R10: idle clocks are quiet
        for (int i = 0; i < 3; i++) beat(0, 5'b11100, "R10");
        // R3 R4: single complete frame
        frame(5'b11100, "R3_R4");
        for (int i = 0; i < 2; i++) beat(0, 5'b11100, "R10");
        // R5: back-to-back frames, R8: scale change on a back-to-back start beat
        frame(5'b11100, "R5");
        frame(5'b11100, "R5");
        frame(5'b11110, "R8");
        // R8: scale change while idle
        beat(0, 5'b00011, "R8");
        beat(0, 5'b10000, "R8");
        frame(5'b10000, "R8");
        // R6: gap inside a frame, then a fresh frame from position 0
        for (int i = 0; i < 3; i++) beat(1, 5'b10000, "R6");
        beat(0, 5'b10000, "R6");
        frame(5'b10000, "R6");
        // R9: error remains through clean traffic
        frame(5'b10000, "R9");
        beat(0, 5'b10000, "R9");
        do_reset();
        // R7: mid-frame scale change flags error, captured word kept
        for (int i = 0; i < 4; i++) beat(1, 5'b11000, "R7");
        for (int i = 0; i < BEATS - 4; i++) beat(1, 5'b00111, "R7");
        frame(5'b00111, "R9");
        // R2: varied lane data with valid toggling outside frames
        beat(0, 5'b00111, "R2");
        frame(5'b00111, "R2");
        beat(0, 5'b00111, "R2");
        beat(0, 5'b00111, "R2");
        do_reset();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule